// File: doc/BRIEF.md
# Speculative L0 filter cache

This block is a small set-associative cache placed between a core's load/store port and a non-speculative L1. Every line brought in by a speculative access lands here and only here, so speculative misses never evict or change anything in the L1. The core issues one request per cycle: a lookup by virtual line address, a fill that carries both virtual and physical line addresses plus the line data and a speculative flag, or a commit notification for a physical line address. When a commit reaches a line that is still uncommitted, the line is marked committed and copied through to the L1 on a write-through port. The line also stays in the filter cache.

A flush input invalidates every entry in one cycle. The core raises it on a context switch, on a system call or kernel entry, and when entering or leaving a sandbox. A branch misprediction does not flush. Valid bits are kept in flops apart from the data storage, so the flush takes one cycle. Because no line ever holds data that the L1 lacks and needs, invalidating is always safe. The default geometry is 8 sets of 4 ways with 64-byte lines (2 KiB). The set index comes from the low bits that the virtual and physical line addresses share.

A small controller registers the outcome of each cycle as one of these states:

- `ACT_IDLE`: no request.
- `ACT_HIT`: the lookup matched.
- `ACT_MISS`: the lookup did not match.
- `ACT_FILL`: a line was written.
- `ACT_CMT_WT`: a commit caused a write-through.
- `ACT_CMT_NOP`: a commit did nothing, because the line was absent or already committed.
- `ACT_FLUSH`: the cache was cleared.

From any state, the next state is chosen only by that cycle's inputs:

- flush takes the controller to `ACT_FLUSH`;
- with no request, it goes to `ACT_IDLE`;
- a lookup goes to `ACT_HIT` or `ACT_MISS`;
- a fill goes to `ACT_FILL`;
- a commit goes to `ACT_CMT_WT` or `ACT_CMT_NOP`.

The outputs are decoded from the registered state.

Top module: `spec_filter_cache`

## Requirements
- R1: A request with `req_op` 0 is a lookup. One cycle later, `rsp_valid` is 1 and `rsp_hit` reports whether a valid entry in set `req_vline[2:0]` holds that virtual line. On a hit, `rsp_data` carries the line. `req_op` 1 is a fill, 2 is a commit, and 3 is ignored.
- R2: A fill with `req_spec`=1 stores the line with its committed bit clear. It produces no write-through.
- R3: A commit for a resident, uncommitted physical line gives a one-cycle `wt_valid` pulse in the next cycle, carrying that physical line address and its data. The line is marked committed and stays resident, so a later lookup still hits.
- R4: A commit for a line that is already committed gives no write-through, including after further speculative lookups of that line.
- R5: A fill with `req_spec`=0 stores the line as already committed, so a later commit for it gives no write-through.
- R6: A commit whose physical line is not resident is ignored, with no write-through and no response.
- R7: A line that is replaced while still uncommitted is dropped and never appears on the write-through port.
- R8: A flush invalidates every entry in one cycle, so a lookup in the very next cycle misses. A fill or commit presented in the same cycle as a flush is dropped.
- R9: In a full set, a fill replaces the least recently used way, where lookup hits and fills count as uses. Invalid ways are filled before any valid way is replaced, and a flush restores the initial age order.
- R10: A fill whose physical line already sits in the set overwrites that entry, including its virtual address, so one physical line has one copy.
- R11: Lines that differ in the index bits never compete for a way: eight lines in eight different sets all stay resident.
- R12: After reset, every entry is invalid and `rsp_valid` and `wt_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries; wins over a request in the same cycle |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lookup, 1 fill, 2 commit, 3 none |
| req_spec | input | 1 | Fill comes from a speculative access |
| req_vline | input | VA_W-OFF_W (26) | Virtual line address (lookup, fill) |
| req_pline | input | PA_W-OFF_W (26) | Physical line address (fill, commit) |
| req_data | input | LINE_BYTES*8 (512) | Fill data |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | LINE_BYTES*8 (512) | Hit data |
| wt_valid | output | 1 | Write-through to L1 this cycle |
| wt_pline | output | PA_W-OFF_W (26) | Physical line written through |
| wt_data | output | LINE_BYTES*8 (512) | Line data written through |

## Verification
Some rules hold in every cycle and are checked there:

- a write-through only follows an accepted commit;
- a response only follows an accepted lookup;
- a flush silences both outputs in the next cycle;
- a repeat commit to the line just written through stays silent.

The bench's directed scenarios are the only place where the rest can be seen. These are the replacement order in a full set, the overwrite of a physical alias, the silent drop of an evicted uncommitted line, the index separation across sets, and the state left behind by a flush. Each of these needs a history of fills and lookups followed by probing lookups.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_FILL   = 2'd1,
        OP_COMMIT = 2'd2,
        OP_NONE   = 2'd3
    } sfc_op_e;

    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_HIT     = 3'd1,
        ACT_MISS    = 3'd2,
        ACT_FILL    = 3'd3,
        ACT_CMT_WT  = 3'd4,
        ACT_CMT_NOP = 3'd5,
        ACT_FLUSH   = 3'd6
    } sfc_act_e;

endpackage

// File: rtl/sfc_lru.sv
// True LRU per set: each way holds an age, 0 = newest, WAYS-1 = oldest.
module sfc_lru #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] set_sel,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim_way
);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[set_sel][w] <= '0;
                else if (age_q[set_sel][w] < age_q[set_sel][touch_way])
                    age_q[set_sel][w] <= age_q[set_sel][w] + WAY_W'(1);
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[set_sel][w] == WAY_W'(WAYS - 1))
                victim_way = WAY_W'(w);
    end

endmodule

// File: rtl/sfc_tags.sv
// Tag, valid and committed storage. Valid bits are flops so flush is one cycle.
module sfc_tags #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int VLN_W = 26,
    parameter int PLN_W = 26,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] set_sel,
    input  logic [VLN_W-1:0] req_vline,
    input  logic [PLN_W-1:0] req_pline,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             fill_committed,
    input  logic             mark_en,
    input  logic [WAY_W-1:0] mark_way,
    output logic [WAYS-1:0]  vhit_vec,
    output logic [WAYS-1:0]  phit_vec,
    output logic [WAYS-1:0]  valid_vec,
    output logic [WAYS-1:0]  comm_vec
);

    logic             valid_q [SETS][WAYS];
    logic             comm_q  [SETS][WAYS];
    logic [VLN_W-1:0] vtag_q  [SETS][WAYS];
    logic [PLN_W-1:0] ptag_q  [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    comm_q[s][w]  <= 1'b0;
                end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    valid_q[s][w] <= 1'b0;
        end else if (fill_en) begin
            valid_q[set_sel][fill_way] <= 1'b1;
            comm_q[set_sel][fill_way]  <= fill_committed;
        end else if (mark_en) begin
            comm_q[set_sel][mark_way]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            vtag_q[set_sel][fill_way] <= req_vline;
            ptag_q[set_sel][fill_way] <= req_pline;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign valid_vec[w] = valid_q[set_sel][w];
        assign comm_vec[w]  = comm_q[set_sel][w];
        assign vhit_vec[w]  = valid_q[set_sel][w] && (vtag_q[set_sel][w] == req_vline);
        assign phit_vec[w]  = valid_q[set_sel][w] && (ptag_q[set_sel][w] == req_pline);
    end

endmodule

// File: rtl/sfc_data.sv
// Line data storage, one write and one read port on the selected set.
module sfc_data #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int LINE_W = 512,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  set_sel,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [LINE_W-1:0] wr_data,
    output logic [LINE_W-1:0] rd_data
);

    logic [LINE_W-1:0] mem_q [SETS*WAYS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[{set_sel, wr_way}] <= wr_data;
    end

    assign rd_data = mem_q[{set_sel, rd_way}];

endmodule

// File: rtl/spec_filter_cache.sv
module spec_filter_cache
    import sfc_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int VLN_W  = VA_W - OFF_W,
    localparam int PLN_W  = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_spec,
    input  logic [VLN_W-1:0]  req_vline,
    input  logic [PLN_W-1:0]  req_pline,
    input  logic [LINE_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              wt_valid,
    output logic [PLN_W-1:0]  wt_pline,
    output logic [LINE_W-1:0] wt_data
);

    function automatic logic [WAY_W-1:0] lowest_set(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--)
            if (v[i]) r = WAY_W'(i);
        return r;
    endfunction

    sfc_op_e          op;
    sfc_act_e         act_q, act_d;
    logic             accept, is_look, is_fill, is_cmt;
    logic [IDX_W-1:0] set_sel;
    logic [WAYS-1:0]  vhit_vec, phit_vec, valid_vec, comm_vec;
    logic [WAY_W-1:0] vway, pway, inv_way, victim_way, fill_way, rd_way;
    logic             any_vhit, any_phit, any_inv;
    logic             look_hit, cmt_wt;
    logic [LINE_W-1:0] rd_data, data_q;
    logic [PLN_W-1:0]  pline_q;

    assign op      = sfc_op_e'(req_op);
    assign accept  = req_valid && !flush;          // flush wins (R8)
    assign is_look = accept && (op == OP_LOOKUP);
    assign is_fill = accept && (op == OP_FILL);
    assign is_cmt  = accept && (op == OP_COMMIT);

    // Lookups index by the virtual line, fills and commits by the physical one;
    // the index bits are common to both.
    assign set_sel = (op == OP_LOOKUP) ? req_vline[IDX_W-1:0] : req_pline[IDX_W-1:0];

    assign any_vhit = |vhit_vec;
    assign any_phit = |phit_vec;
    assign any_inv  = ~&valid_vec;
    assign vway     = lowest_set(vhit_vec);
    assign pway     = lowest_set(phit_vec);
    assign inv_way  = lowest_set(~valid_vec);

    // Physical alias first, then a free way, then the oldest way.
    assign fill_way = any_phit ? pway : (any_inv ? inv_way : victim_way);
    assign look_hit = is_look && any_vhit;
    assign cmt_wt   = is_cmt && any_phit && !comm_vec[pway];
    assign rd_way   = is_look ? vway : pway;

    sfc_tags #(
        .SETS(SETS), .WAYS(WAYS), .VLN_W(VLN_W), .PLN_W(PLN_W)
    ) u_tags (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .set_sel        (set_sel),
        .req_vline      (req_vline),
        .req_pline      (req_pline),
        .fill_en        (is_fill),
        .fill_way       (fill_way),
        .fill_committed (!req_spec),
        .mark_en        (cmt_wt),
        .mark_way       (pway),
        .vhit_vec       (vhit_vec),
        .phit_vec       (phit_vec),
        .valid_vec      (valid_vec),
        .comm_vec       (comm_vec)
    );

    sfc_data #(
        .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (is_fill),
        .set_sel (set_sel),
        .wr_way  (fill_way),
        .rd_way  (rd_way),
        .wr_data (req_data),
        .rd_data (rd_data)
    );

    sfc_lru #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .touch_en   (look_hit || is_fill),
        .set_sel    (set_sel),
        .touch_way  (is_fill ? fill_way : vway),
        .victim_way (victim_way)
    );

    // Next-state selection from this cycle's inputs.
    always_comb begin
        act_d = ACT_IDLE;
        if (flush) begin
            act_d = ACT_FLUSH;
        end else if (req_valid) begin
            unique case (op)
                OP_LOOKUP: act_d = any_vhit ? ACT_HIT : ACT_MISS;
                OP_FILL:   act_d = ACT_FILL;
                OP_COMMIT: act_d = cmt_wt ? ACT_CMT_WT : ACT_CMT_NOP;
                OP_NONE:   act_d = ACT_IDLE;
                default:   act_d = ACT_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= ACT_IDLE;
        else        act_q <= act_d;
    end

    // Payload registers captured alongside the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            pline_q <= '0;
        end else begin
            if (look_hit || cmt_wt) data_q <= rd_data;
            if (cmt_wt)             pline_q <= req_pline;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        wt_valid  = 1'b0;
        unique case (act_q)
            ACT_HIT:     begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            ACT_MISS:    rsp_valid = 1'b1;
            ACT_CMT_WT:  wt_valid  = 1'b1;
            ACT_IDLE, ACT_FILL, ACT_CMT_NOP, ACT_FLUSH: ;
            default: ;
        endcase
    end

    assign rsp_data = data_q;
    assign wt_data  = data_q;
    assign wt_pline = pline_q;

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int PLN_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [PLN_W-1:0] req_pline,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             wt_valid,
    input logic [PLN_W-1:0] wt_pline
);

    // R1: a response appears exactly one cycle after an accepted lookup.
    p_rsp_follows_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && !flush) |=> rsp_valid);

    p_rsp_needs_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_op == 2'd0 && !flush));

    p_hit_implies_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R2, R7: the write-through port only moves after an accepted commit.
    p_wt_needs_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> $past(req_valid && req_op == 2'd2 && !flush));

    // R4: committing the line just written through again stays silent.
    p_no_repeat_wt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_valid && req_valid && req_op == 2'd2 && !flush && req_pline == wt_pline)
        |=> !wt_valid);

    // R8: a flush drops any request of its cycle.
    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rsp_valid && !wt_valid));

    p_outputs_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, wt_valid}));

endmodule

bind spec_filter_cache sfc_checker #(.PLN_W(PLN_W)) u_sfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_pline (req_pline),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .wt_valid  (wt_valid),
    .wt_pline  (wt_pline)
);

// File: tb/test_spec_filter_cache.sv
module test_spec_filter_cache;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 512;
    localparam int LN = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd3;
    logic          req_spec = 1'b0;
    logic [LN-1:0] req_vline = '0;
    logic [LN-1:0] req_pline = '0;
    logic [LW-1:0] req_data = '0;
    logic          rsp_valid, rsp_hit, wt_valid;
    logic [LW-1:0] rsp_data, wt_data;
    logic [LN-1:0] wt_pline;

    int checks = 0;
    int errors = 0;
    int wt_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_filter_cache i_spec_filter_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_op(req_op), .req_spec(req_spec),
        .req_vline(req_vline), .req_pline(req_pline), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .wt_valid(wt_valid), .wt_pline(wt_pline), .wt_data(wt_data)
    );

    // L1 side model: counts write-through pulses.
    always @(posedge clk) if (rst_n && wt_valid) wt_seen++;

    function automatic logic [LN-1:0] ln(input int tag, input int idx);
        return {23'(tag), 3'(idx)};
    endfunction

    function automatic logic [LW-1:0] mk(input logic [31:0] seed);
        return {16{seed}};
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic spec, input logic [LN-1:0] v,
                        input logic [LN-1:0] p, input logic [LW-1:0] d, input logic fl);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_spec = spec;
        req_vline = v; req_pline = p; req_data = d; flush = fl;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd3; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic fill(input logic spec, input logic [LN-1:0] v, input logic [LN-1:0] p,
                        input logic [LW-1:0] d);
        send(2'd1, spec, v, p, d, 1'b0);
    endtask

    task automatic expect_lookup(input string what, input logic [LN-1:0] v, input logic hit,
                                 input logic [LW-1:0] d);
        send(2'd0, 1'b0, v, '0, '0, 1'b0);
        check({what, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({what, " hit"}, 64'(rsp_hit), 64'(hit));
        if (hit) begin
            check({what, " data lo"}, rsp_data[63:0], d[63:0]);
            check({what, " data hi"}, rsp_data[LW-1:LW-64], d[LW-1:LW-64]);
        end
    endtask

    task automatic expect_commit(input string what, input logic [LN-1:0] p, input logic wt,
                                 input logic [LW-1:0] d);
        send(2'd2, 1'b0, '0, p, '0, 1'b0);
        check({what, " wt_valid"}, 64'(wt_valid), 64'(wt));
        check({what, " rsp_valid"}, 64'(rsp_valid), 64'd0);
        if (wt) begin
            check({what, " wt_pline"}, 64'(wt_pline), 64'(p));
            check({what, " wt_data"}, wt_data[63:0], d[63:0]);
        end
    endtask

    task automatic t_reset();
        check("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R12 wt_valid after reset", 64'(wt_valid), 64'd0);
        expect_lookup("R12 lookup after reset", ln(1, 0), 1'b0, '0);
    endtask

    task automatic t_spec_commit();
        int w0;
        w0 = wt_seen;
        fill(1'b1, ln(5, 3), ln(9, 3), mk(32'h1111_0001));
        check("R2 no wt on spec fill", 64'(wt_valid), 64'd0);
        expect_lookup("R1 hit after fill", ln(5, 3), 1'b1, mk(32'h1111_0001));
        expect_lookup("R1 miss other line", ln(6, 3), 1'b0, '0);
        expect_commit("R3 first commit", ln(9, 3), 1'b1, mk(32'h1111_0001));
        expect_lookup("R3 line stays resident", ln(5, 3), 1'b1, mk(32'h1111_0001));
        expect_commit("R4 second commit", ln(9, 3), 1'b0, '0);
        @(negedge clk);
        check("R3 exactly one wt pulse", 64'(wt_seen - w0), 64'd1);
    endtask

    task automatic t_nonspec();
        fill(1'b0, ln(40, 1), ln(41, 1), mk(32'h2222_0002));
        check("R5 no wt on nonspec fill", 64'(wt_valid), 64'd0);
        expect_lookup("R5 nonspec line hits", ln(40, 1), 1'b1, mk(32'h2222_0002));
        expect_commit("R5 commit of committed line", ln(41, 1), 1'b0, '0);
    endtask

    task automatic t_commit_miss();
        expect_commit("R6 commit to absent line", ln(99, 6), 1'b0, '0);
    endtask

    task automatic t_lru();
        int w0;
        do_flush();
        w0 = wt_seen;
        for (int i = 0; i < 4; i++)
            fill(1'b1, ln(10 + i, 2), ln(10 + i, 2), mk(32'h3300_0000 + i));
        expect_lookup("R9 refresh oldest", ln(10, 2), 1'b1, mk(32'h3300_0000));
        fill(1'b1, ln(14, 2), ln(14, 2), mk(32'h3300_0004));
        expect_lookup("R9 LRU way evicted", ln(11, 2), 1'b0, '0);
        expect_lookup("R9 refreshed way kept", ln(10, 2), 1'b1, mk(32'h3300_0000));
        expect_lookup("R9 new line present", ln(14, 2), 1'b1, mk(32'h3300_0004));
        expect_lookup("R9 other way kept", ln(12, 2), 1'b1, mk(32'h3300_0002));
        @(negedge clk);
        check("R7 evicted uncommitted line not written", 64'(wt_seen - w0), 64'd0);
        expect_commit("R7 commit after eviction", ln(11, 2), 1'b0, '0);
    endtask

    task automatic t_alias();
        do_flush();
        fill(1'b1, ln(20, 5), ln(30, 5), mk(32'h4400_00A1));
        fill(1'b1, ln(21, 5), ln(31, 5), mk(32'h4400_00A2));
        fill(1'b1, ln(22, 5), ln(30, 5), mk(32'h4400_00A3));
        expect_lookup("R10 old virtual alias gone", ln(20, 5), 1'b0, '0);
        expect_lookup("R10 new virtual alias", ln(22, 5), 1'b1, mk(32'h4400_00A3));
        expect_lookup("R10 neighbour kept", ln(21, 5), 1'b1, mk(32'h4400_00A2));
        expect_commit("R10 single copy written", ln(30, 5), 1'b1, mk(32'h4400_00A3));
        // Fourth and fifth fills prove the alias used one way only.
        fill(1'b1, ln(23, 5), ln(32, 5), mk(32'h4400_00A4));
        fill(1'b1, ln(24, 5), ln(33, 5), mk(32'h4400_00A5));
        expect_lookup("R10 set not overfilled", ln(21, 5), 1'b1, mk(32'h4400_00A2));
    endtask

    task automatic t_flush();
        fill(1'b1, ln(1, 0), ln(1, 0), mk(32'h5500_0001));
        fill(1'b0, ln(2, 1), ln(2, 1), mk(32'h5500_0002));
        do_flush();
        expect_lookup("R8 spec line gone after flush", ln(1, 0), 1'b0, '0);
        expect_lookup("R8 committed line gone after flush", ln(2, 1), 1'b0, '0);
        fill(1'b1, ln(3, 2), ln(3, 2), mk(32'h5500_0003));
        send(2'd2, 1'b0, '0, ln(3, 2), '0, 1'b1);
        check("R8 commit dropped by flush", 64'(wt_valid), 64'd0);
        check("R8 no response on flush", 64'(rsp_valid), 64'd0);
        expect_lookup("R8 flushed line misses", ln(3, 2), 1'b0, '0);
        send(2'd1, 1'b1, ln(4, 3), ln(4, 3), mk(32'h5500_0004), 1'b1);
        expect_lookup("R8 fill dropped by flush", ln(4, 3), 1'b0, '0);
        expect_commit("R8 commit after flush", ln(3, 2), 1'b0, '0);
    endtask

    task automatic t_sets();
        do_flush();
        for (int i = 0; i < 8; i++)
            fill(1'b1, ln(7, i), ln(7, i), mk(32'h6600_0000 + i));
        for (int i = 0; i < 8; i++)
            expect_lookup("R11 line in own set", ln(7, i), 1'b1, mk(32'h6600_0000 + i));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spec_commit();
        t_nonspec();
        t_commit_miss();
        t_lru();
        t_alias();
        t_flush();
        t_sets();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule